// File: doc/BRIEF.md
# Flag-Setting Adder with Condition Evaluator

This block adds two operands with a carry input and derives four status flags from the result: negative, zero, carry and overflow. The sum and the freshly computed flags are registered and presented one clock after the operands. When the flag write enable is high, the new flags are also stored in a four-bit flag register. A four-bit condition code is tested against that stored flag register, and the outcome appears on a single output.

The datapath is `DATA_W` bits wide (64 by default). A mode input narrows the operation to the lower half (32 bits). The caller performs subtraction by supplying the bitwise complement of the second operand and setting the carry input. A synchronous reset clears the registered outputs and loads every stored flag with the value on the cold-reset input.

Top module: `addflag_unit`

## Requirements
- R1: One cycle after the operands are presented, `sum_out` holds the low bits of `a_in + b_in + carry_in` at the active width. In narrow mode (`narrow` = 1) the upper half of `sum_out` is zero.
- R2: `flags_new` packs negative at bit 3, zero at bit 2, carry at bit 1 and overflow at bit 0. Negative is the top bit of the result at the active width (bit 63 or bit 31). Zero is set when every result bit at the active width is 0.
- R3: The carry flag is set when the unsigned value of `a + b + carry_in` does not equal the unsigned value of the truncated result.
- R4: The overflow flag is set when the signed value of `a + b + carry_in` does not equal the signed value of the truncated result.
- R5: In narrow mode the upper input bits of both operands have no effect on the sum or on the flags.
- R6: The stored flag register takes `flags_new`'s value at a clock edge where `flag_we` is high, and it holds its value at every other edge.
- R7: While `rst` is high, a clock edge clears `sum_out` and `flags_new` and loads all four stored flags with `cold_rst`.
- R8: `cond[3:1]` selects the test on the stored flags: 000 zero set, 001 carry set, 010 negative set, 011 overflow set, 100 carry set and zero clear, 101 negative equals overflow, 110 negative equals overflow and zero clear, 111 true.
- R9: When `cond[0]` is 1, the result of the test is inverted, except for code 1111. Codes 1110 and 1111 both give 1.
- R10: `cond_true` follows `cond` within the same cycle and reads only the stored flags. A flag write therefore shows on `cond_true` just after the clock edge that stores it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cold_rst | input | 1 | Value loaded into every stored flag during reset |
| a_in | input | DATA_W | First operand |
| b_in | input | DATA_W | Second operand |
| carry_in | input | 1 | Carry into the least significant bit |
| narrow | input | 1 | 1 selects half-width operation |
| flag_we | input | 1 | Stores the new flags at the next clock edge |
| cond | input | 4 | Condition code to test |
| sum_out | output | DATA_W | Registered sum |
| flags_new | output | 4 | Registered flags of the last operation, packed {N,Z,C,V} |
| cond_true | output | 1 | Result of testing `cond` against the stored flags |

## Verification
The properties assume that `rst` is held for at least one full clock edge. They also assume that `narrow`, the operands and `flag_we` are stable around each rising edge, so that a registered result can be paired with the mode sampled one edge earlier. The stimulus changes every input only on falling edges. It holds reset for whole cycles and clears `flag_we` during the condition sweeps, so that the stored flags being checked stay fixed. The narrow-mode operands carry deliberately non-zero upper halves, which the requirements say must be ignored.

// File: rtl/addflag_pkg.sv
package addflag_pkg;

  localparam int FLAG_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [2:0] {
    T_ZERO   = 3'b000,
    T_CARRY  = 3'b001,
    T_NEG    = 3'b010,
    T_OVF    = 3'b011,
    T_UHIGH  = 3'b100,
    T_SGE    = 3'b101,
    T_SGT    = 3'b110,
    T_ALWAYS = 3'b111
  } base_e;

endpackage

// File: rtl/addflag_core.sv
module addflag_core
  import addflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              narrow,
  output logic [DATA_W-1:0] sum,
  output flags_t            flg
);

  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W:0] lo_ext;
  logic [HALF_W:0] hi_ext;

  // two chained half-width lanes; the lower lane carry-out is the narrow carry
  always_comb begin
    lo_ext = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    hi_ext = {1'b0, a[DATA_W-1:HALF_W]} + {1'b0, b[DATA_W-1:HALF_W]}
           + {{HALF_W{1'b0}}, lo_ext[HALF_W]};
  end

  always_comb begin
    if (narrow) begin
      sum   = {{HALF_W{1'b0}}, lo_ext[HALF_W-1:0]};
      flg.n = lo_ext[HALF_W-1];
      flg.z = (lo_ext[HALF_W-1:0] == '0);
      flg.c = lo_ext[HALF_W];
      flg.v = (a[HALF_W-1] == b[HALF_W-1]) && (lo_ext[HALF_W-1] != a[HALF_W-1]);
    end else begin
      sum   = {hi_ext[HALF_W-1:0], lo_ext[HALF_W-1:0]};
      flg.n = hi_ext[HALF_W-1];
      flg.z = (hi_ext[HALF_W-1:0] == '0) && (lo_ext[HALF_W-1:0] == '0);
      flg.c = hi_ext[HALF_W];
      flg.v = (a[DATA_W-1] == b[DATA_W-1]) && (hi_ext[HALF_W-1] != a[DATA_W-1]);
    end
  end

endmodule

// File: rtl/addflag_flagreg.sv
module addflag_flagreg
  import addflag_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cold_rst,
  input  logic   we,
  input  flags_t d,
  output flags_t q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= flags_t'({FLAG_W{cold_rst}});
    else if (we) q <= d;
  end

endmodule

// File: rtl/addflag_cond.sv
module addflag_cond
  import addflag_pkg::*;
(
  input  flags_t     f,
  input  logic [3:0] code,
  output logic       hit
);

  base_e sel;
  logic  base;

  always_comb begin
    sel = base_e'(code[3:1]);
    unique case (sel)
      T_ZERO:   base = f.z;
      T_CARRY:  base = f.c;
      T_NEG:    base = f.n;
      T_OVF:    base = f.v;
      T_UHIGH:  base = f.c && !f.z;
      T_SGE:    base = (f.n == f.v);
      T_SGT:    base = (f.n == f.v) && !f.z;
      default:  base = 1'b1;
    endcase
    hit = (code[0] && (code != 4'b1111)) ? !base : base;
  end

endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
  import addflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cold_rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              carry_in,
  input  logic              narrow,
  input  logic              flag_we,
  input  logic [3:0]        cond,
  output logic [DATA_W-1:0] sum_out,
  output logic [3:0]        flags_new,
  output logic              cond_true
);

  logic [DATA_W-1:0] sum_c;
  flags_t            flg_c;
  flags_t            flag_q;

  addflag_core #(.DATA_W(DATA_W)) u_core (
    .a      (a_in),
    .b      (b_in),
    .cin    (carry_in),
    .narrow (narrow),
    .sum    (sum_c),
    .flg    (flg_c)
  );

  addflag_flagreg u_flags (
    .clk      (clk),
    .rst      (rst),
    .cold_rst (cold_rst),
    .we       (flag_we),
    .d        (flg_c),
    .q        (flag_q)
  );

  addflag_cond u_cond (
    .f    (flag_q),
    .code (cond),
    .hit  (cond_true)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      flags_new <= '0;
    end else begin
      sum_out   <= sum_c;
      flags_new <= flg_c;
    end
  end

endmodule

// File: rtl/addflag_checker.sv
module addflag_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cold_rst,
  input logic              narrow,
  input logic              flag_we,
  input logic [3:0]        cond,
  input logic [DATA_W-1:0] sum_out,
  input logic [3:0]        flags_new,
  input logic              cond_true,
  input logic [3:0]        flag_q
);

  localparam int HALF_W = DATA_W / 2;

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(narrow) |-> (sum_out[DATA_W-1:HALF_W] == '0));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flags_new[2] ==
      ($past(narrow) ? (sum_out[HALF_W-1:0] == '0) : (sum_out == '0))));

  p_neg_flag_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flags_new[3] ==
      ($past(narrow) ? sum_out[HALF_W-1] : sum_out[DATA_W-1])));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_we) && !$past(rst)) |-> (flag_q == flags_new));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(flag_we) && !$past(rst)) |-> (flag_q == $past(flag_q)));

  p_cold_load_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag_q == {4{$past(cold_rst)}}));

  p_zero_test_r8: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'b0000) |-> (cond_true == flag_q[2]));

  p_always_true_r9: assert property (@(posedge clk) disable iff (rst)
    (cond[3:1] == 3'b111) |-> cond_true);

endmodule

bind addflag_unit addflag_checker #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cold_rst  (cold_rst),
  .narrow    (narrow),
  .flag_we   (flag_we),
  .cond      (cond),
  .sum_out   (sum_out),
  .flags_new (flags_new),
  .cond_true (cond_true),
  .flag_q    (flag_q)
);

// File: tb/test_addflag_unit.sv
module test_addflag_unit;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cold_rst = 1'b0;
  logic [DATA_W-1:0] a_in = '0;
  logic [DATA_W-1:0] b_in = '0;
  logic              carry_in = 1'b0;
  logic              narrow = 1'b0;
  logic              flag_we = 1'b0;
  logic [3:0]        cond = 4'b0;
  logic [DATA_W-1:0] sum_out;
  logic [3:0]        flags_new;
  logic              cond_true;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] mflags = 4'b0;

  typedef struct {
    logic [63:0] s;
    logic [3:0]  f;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  addflag_unit #(.DATA_W(DATA_W)) i_addflag_unit (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .a_in(a_in), .b_in(b_in),
    .carry_in(carry_in), .narrow(narrow), .flag_we(flag_we), .cond(cond),
    .sum_out(sum_out), .flags_new(flags_new), .cond_true(cond_true)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected sum and flags from the arithmetic definitions (R1..R5)
  function automatic logic [67:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic ci, input logic nar);
    logic [65:0] ua, ub, usum, ures;
    logic signed [65:0] sa, sb, ssum, sres;
    logic [63:0] res;
    logic n, z, c, v;
    if (nar) begin
      ua = {34'b0, a[31:0]};
      ub = {34'b0, b[31:0]};
      sa = $signed({{34{a[31]}}, a[31:0]});
      sb = $signed({{34{b[31]}}, b[31:0]});
    end else begin
      ua = {2'b0, a};
      ub = {2'b0, b};
      sa = $signed({{2{a[63]}}, a});
      sb = $signed({{2{b[63]}}, b});
    end
    usum = ua + ub + {65'b0, ci};
    ssum = sa + sb + $signed({65'b0, ci});
    if (nar) begin
      res  = {32'b0, usum[31:0]};
      ures = {34'b0, usum[31:0]};
      sres = $signed({{34{usum[31]}}, usum[31:0]});
      n = usum[31];
      z = (usum[31:0] == 32'b0);
    end else begin
      res  = usum[63:0];
      ures = {2'b0, usum[63:0]};
      sres = $signed({{2{usum[63]}}, usum[63:0]});
      n = usum[63];
      z = (usum[63:0] == 64'b0);
    end
    c = (ures != usum);
    v = (sres != ssum);
    return {res, n, z, c, v};
  endfunction

  // condition meaning per R8 and R9
  function automatic logic cond_model(input logic [3:0] f, input logic [3:0] code);
    logic n, z, c, v, r;
    {n, z, c, v} = f;
    case (code[3:1])
      3'd0: r = z;
      3'd1: r = c;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = c & ~z;
      3'd5: r = (n == v);
      3'd6: r = (n == v) & ~z;
      default: r = 1'b1;
    endcase
    if (code[0] && code != 4'hF) r = ~r;
    return r;
  endfunction

  // driver: presents one operation, queues its expected result
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic ci,
                        input logic nar, input logic we, input string tag);
    logic [67:0] m;
    exp_t e;
    @(negedge clk);
    a_in = a; b_in = b; carry_in = ci; narrow = nar; flag_we = we;
    op_valid = 1'b1;
    m = model(a, b, ci, nar);
    e.s = m[67:4]; e.f = m[3:0]; e.tag = tag;
    sb_q.push_back(e);
    if (we) mflags = m[3:0];
  endtask

  // monitor: compares the registered result one edge after the operation
  always @(posedge clk) begin
    if (op_valid) begin
      exp_t e;
      #1;
      if (sb_q.size() == 0) begin
        check(1'b0, "scoreboard empty", 64'(sum_out), 64'b0);
      end else begin
        e = sb_q.pop_front();
        check(sum_out == e.s, {e.tag, " sum"}, sum_out, e.s);
        check(flags_new == e.f, {e.tag, " flags"}, 64'(flags_new), 64'(e.f));
      end
    end
  end

  task automatic scan_conds(input string tag);
    for (int code = 0; code < 16; code++) begin
      @(negedge clk);
      op_valid = 1'b0; flag_we = 1'b0; cond = code[3:0];
      #1;
      check(cond_true == cond_model(mflags, code[3:0]),
            $sformatf("%s code=%0d flags=%b", tag, code, mflags),
            64'(cond_true), 64'(cond_model(mflags, code[3:0])));
    end
  endtask

  task automatic do_reset(input logic cold);
    @(negedge clk);
    op_valid = 1'b0; flag_we = 1'b1; rst = 1'b1; cold_rst = cold;
    a_in = '1; b_in = 64'd1;
    @(negedge clk);
    rst = 1'b0; flag_we = 1'b0;
    #1;
    check(sum_out == '0, "R7 reset sum", sum_out, 64'b0);
    check(flags_new == 4'b0, "R7 reset flags_new", 64'(flags_new), 64'b0);
    mflags = {4{cold}};
    scan_conds("R7 R8 R9 after reset");
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset(1'b1);
    do_reset(1'b0);

    // wide operations, R1 R2 R3 R4
    run_op(64'h0, 64'h0, 1'b0, 1'b0, 1'b1, "R1 R2 zero sum");
    run_op(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 1'b1, 1'b0, 1'b1, "R1 plain add");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 1'b1, "R3 carry wrap");
    scan_conds("R8 R9 Z+C");
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 1'b1, "R4 overflow via carry_in");
    scan_conds("R8 R9 N+V");
    run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, "R3 R4 neg overflow");
    scan_conds("R8 R9 Z+C+V");
    run_op(64'd5, ~64'd9, 1'b1, 1'b0, 1'b1, "R2 R3 subtract borrow");
    run_op(64'd9, ~64'd5, 1'b1, 1'b0, 1'b1, "R3 subtract no borrow");
    scan_conds("R8 R9 C only");

    // narrow operations with junk upper halves, R5
    run_op(64'hDEAD_BEEF_7FFF_FFFF, 64'hCAFE_F00D_0000_0001, 1'b0, 1'b1, 1'b1, "R5 R4 narrow overflow");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 1'b0, 1'b1, 1'b1, "R5 R3 narrow carry");
    run_op(64'hA5A5_A5A5_8000_0000, 64'h5A5A_5A5A_0000_0000, 1'b0, 1'b1, 1'b1, "R5 R2 narrow negative");
    scan_conds("R8 R9 N only");

    // hold when write enable low, R6
    run_op(64'h0, 64'h0, 1'b0, 1'b0, 1'b0, "R6 no write op");
    scan_conds("R6 flags held");

    // write visible only after the storing edge, R10
    @(negedge clk);
    op_valid = 1'b0; flag_we = 1'b0; cond = 4'b0000;
    #1;
    check(cond_true == 1'b0, "R10 before write", 64'(cond_true), 64'b0);
    run_op(64'h0, 64'h0, 1'b0, 1'b0, 1'b1, "R10 write zero");
    cond = 4'b0000;
    #1;
    check(cond_true == 1'b0, "R10 same cycle unchanged", 64'(cond_true), 64'b0);
    @(posedge clk);
    #2;
    check(cond_true == 1'b1, "R10 after edge", 64'(cond_true), 64'b1);
    scan_conds("R8 R9 Z only");

    @(negedge clk);
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R1 scoreboard drained", 64'(sb_q.size()), 64'b0);
    finish_up();
  end

endmodule